// File: doc/BRIEF.md
# Host-Firmware Mailbox With Ownership Arbitration

This block is a small register-mapped mailbox. A host processor and the firmware of an embedded controller use it to exchange 32-bit messages. The host reaches it through a plain write strobe with address and data and a combinational read port. The firmware side is a direct signal port. Through it the firmware can claim the mailbox, post an outbound message and report that it has hung.

An owner register decides which side may use the mailbox. It holds one of three values: none, firmware or host software. The host claims by writing the software code and then reads the register back to see whether the claim held. A transmission is finished once the owner reads none again. To send, the host loads the inbound data register and then writes the command register with the interrupt-enable and firmware-target bits set. This makes a one-cycle doorbell toward the firmware and captures the message for it. Replies that acknowledge or reject a firmware request are sent the same way without a claim, because the firmware still holds the mailbox. When the firmware posts a message, the block sets the host-target bit. The host interrupt is then raised while the interrupt-enable bit is also set. A separate status register holds a sticky firmware-hang flag and its own enable. The host clears the flag by writing ones.

Top module: `hfmbox`

## Requirements
- R1: After reset every register reads 0, the owner is none, and fw_doorbell and host_irq are low.
- R2: The registers are at these addresses: command 0xE4, inbound data 0xE8, outbound data 0xEC (read only), owner 0xF0, interrupt status 0x428. Any other address reads 0. Command bits 31, 30, 29 and 28 are stored and read back. A message word keeps its 8-bit type in bits 31:24 and its 24-bit payload in bits 23:0, unchanged.
- R3: The owner codes are 0 for none, 1 for firmware and 2 for host software; the value 3 never appears. A host write of 2 while the owner is none makes the owner read 2. A host write of 0 releases the mailbox from any owner.
- R4: A claim against a different holder is ignored. A host write of 2 while firmware owns leaves 1. A firmware claim while the host owns leaves 2. A host write of 1 or 3 leaves the owner unchanged.
- R5: If a firmware claim and a host write of 2 land in the same cycle while the owner is none, firmware wins and the owner reads 1.
- R6: A command write with bits 31 and 27 both set raises fw_doorbell for exactly the next cycle, and fw_inbox then shows the inbound data. Bit 27 is consumed and always reads 0. A write with bit 27 set but bit 31 clear gives no doorbell.
- R7: The doorbell does not depend on the owner. A send while firmware owns still rings, and the owner stays 1.
- R8: A firmware post stores fw_msg in the outbound register and sets command bit 29. host_irq is high while bits 29 and 31 are both set. Clearing bit 29 drops it.
- R9: If a firmware post and a host command write that clears bit 29 fall in the same cycle, bit 29 ends set and the new message is stored.
- R10: A firmware hang sets status bit 1. host_irq is also high while bit 1 and enable bit 3 are both set. Writing back the value read clears bit 1 and keeps the enable. A new hang in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | AW | Host register address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr, combinational |
| fw_claim | input | 1 | Firmware ownership claim |
| fw_post | input | 1 | Firmware posts fw_msg outbound |
| fw_msg | input | 32 | Firmware outbound message word |
| fw_hang | input | 1 | Firmware hang report |
| fw_doorbell | output | 1 | One-cycle doorbell toward firmware |
| fw_inbox | output | 32 | Message captured for firmware at the doorbell |
| host_irq | output | 1 | Interrupt toward the host |

## Verification
Three pairs of events can land on the same clock edge, and each is set up on purpose by driving both inputs on one falling edge:
- A firmware claim can arrive together with a host claim on a free mailbox. The result is judged by reading back the owner.
- A firmware post can arrive together with the host's read-modify-write that clears the host-target bit. The check is that the bit, the interrupt and the new outbound word all survive.
- A hang report can arrive together with the host's write-one-to-clear of the status. The check is that the flag stays set.

// File: rtl/hfmbox.sv
module hfmbox #(
  parameter int AW = 12,
  parameter logic [AW-1:0] CMD_OFS = 'hE4,
  parameter logic [AW-1:0] IN_OFS  = 'hE8,
  parameter logic [AW-1:0] OUT_OFS = 'hEC,
  parameter logic [AW-1:0] OWN_OFS = 'hF0,
  parameter logic [AW-1:0] ST_OFS  = 'h428
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_wr,
  input  logic [AW-1:0] h_addr,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  input  logic          fw_claim,
  input  logic          fw_post,
  input  logic [31:0]   fw_msg,
  input  logic          fw_hang,
  output logic          fw_doorbell,
  output logic [31:0]   fw_inbox,
  output logic          host_irq
);
  localparam logic [1:0] OWN_NONE = 2'd0, OWN_FW = 2'd1, OWN_SW = 2'd2;

  logic        ie_q, xhci_q, smi_q, pme_q;
  logic [31:0] in_q, out_q, inbox_q;
  logic [1:0]  own_q, own_d;
  logic        hang_q, sen_q, db_q;

  wire wr_cmd = h_wr && (h_addr == CMD_OFS);
  wire wr_in  = h_wr && (h_addr == IN_OFS);
  wire wr_own = h_wr && (h_addr == OWN_OFS);
  wire wr_st  = h_wr && (h_addr == ST_OFS);
  wire ring   = wr_cmd && h_wdata[31] && h_wdata[27];

  always_comb begin
    own_d = own_q;
    if (wr_own && h_wdata == 32'd0)
      own_d = OWN_NONE;
    else if (fw_claim && own_q == OWN_NONE)
      own_d = OWN_FW;
    else if (wr_own && h_wdata == {30'd0, OWN_SW} && own_q != OWN_FW)
      own_d = OWN_SW;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q    <= 1'b0;
      xhci_q  <= 1'b0;
      smi_q   <= 1'b0;
      pme_q   <= 1'b0;
      in_q    <= '0;
      out_q   <= '0;
      inbox_q <= '0;
      own_q   <= OWN_NONE;
      hang_q  <= 1'b0;
      sen_q   <= 1'b0;
      db_q    <= 1'b0;
    end else begin
      own_q <= own_d;
      db_q  <= ring;
      if (ring) inbox_q <= in_q;
      if (wr_in) in_q <= h_wdata;
      if (fw_post) out_q <= fw_msg;
      if (wr_cmd) begin
        ie_q   <= h_wdata[31];
        xhci_q <= h_wdata[30];
        pme_q  <= h_wdata[28];
        smi_q  <= h_wdata[29] | fw_post;
      end else if (fw_post) begin
        smi_q <= 1'b1;
      end
      hang_q <= fw_hang | (hang_q & ~(wr_st & h_wdata[1]));
      if (wr_st) sen_q <= h_wdata[3];
    end
  end

  always_comb begin
    h_rdata = '0;
    if (h_addr == CMD_OFS)      h_rdata = {ie_q, xhci_q, smi_q, pme_q, 28'd0};
    else if (h_addr == IN_OFS)  h_rdata = in_q;
    else if (h_addr == OUT_OFS) h_rdata = out_q;
    else if (h_addr == OWN_OFS) h_rdata = {30'd0, own_q};
    else if (h_addr == ST_OFS)  h_rdata = {28'd0, sen_q, 1'b0, hang_q, 1'b0};
  end

  assign fw_doorbell = db_q;
  assign fw_inbox    = inbox_q;
  assign host_irq    = (smi_q & ie_q) | (hang_q & sen_q);
endmodule

// File: rtl/hfmbox_chk.sv
module hfmbox_chk #(
  parameter int AW = 12,
  parameter logic [AW-1:0] CMD_OFS = 'hE4,
  parameter logic [AW-1:0] OWN_OFS = 'hF0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_wr,
  input logic [AW-1:0] h_addr,
  input logic [31:0]   h_wdata,
  input logic          fw_post,
  input logic          fw_hang,
  input logic          fw_doorbell,
  input logic          host_irq,
  input logic [1:0]    own_q,
  input logic          smi_q,
  input logic          hang_q
);
  wire rel = h_wr && (h_addr == OWN_OFS) && (h_wdata == 32'd0);

  AST_OWN_ENCODED: assert property (@(posedge clk) disable iff (!rst_n) own_q != 2'd3); // R3
  AST_FW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (own_q == 2'd1 && !rel) |=> own_q == 2'd1); // R4
  AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (own_q == 2'd2 && !rel) |=> own_q == 2'd2); // R4
  AST_DB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fw_doorbell |-> $past(h_wr && h_addr == CMD_OFS && h_wdata[31] && h_wdata[27])); // R6
  AST_POST_FLAG: assert property (@(posedge clk) disable iff (!rst_n) fw_post |=> smi_q); // R9
  AST_HANG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) fw_hang |=> hang_q); // R10
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) host_irq |-> (smi_q || hang_q)); // R8
endmodule

bind hfmbox hfmbox_chk #(.AW(AW), .CMD_OFS(CMD_OFS), .OWN_OFS(OWN_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
  .fw_post(fw_post), .fw_hang(fw_hang), .fw_doorbell(fw_doorbell),
  .host_irq(host_irq), .own_q(own_q), .smi_q(smi_q), .hang_q(hang_q)
);

// File: tb/hfmbox_test.sv
`timescale 1ns/1ps
module hfmbox_test;
  localparam logic [11:0] A_CMD = 12'hE4, A_IN = 12'hE8, A_OUT = 12'hEC,
                          A_OWN = 12'hF0, A_ST = 12'h428;
  logic clk = 0, rst_n = 0, h_wr = 0, fw_claim = 0, fw_post = 0, fw_hang = 0;
  logic [11:0] h_addr = 0;
  logic [31:0] h_wdata = 0, fw_msg = 0, h_rdata, fw_inbox;
  logic fw_doorbell, host_irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hfmbox uut (.clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .fw_claim(fw_claim), .fw_post(fw_post), .fw_msg(fw_msg),
    .fw_hang(fw_hang), .fw_doorbell(fw_doorbell), .fw_inbox(fw_inbox), .host_irq(host_irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    h_wr = 1; h_addr = a; h_wdata = d;
    @(posedge clk); @(negedge clk);
    h_wr = 0;
  endtask

  task automatic hread(input logic [11:0] a, output logic [31:0] d);
    h_addr = a; #1; d = h_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    hread(A_CMD, v); check("R1 cmd", v, 0);
    hread(A_IN, v);  check("R1 in", v, 0);
    hread(A_OUT, v); check("R1 out", v, 0);
    hread(A_OWN, v); check("R1 owner", v, 0);
    hread(A_ST, v);  check("R1 status", v, 0);
    check("R1 doorbell", fw_doorbell, 0);
    check("R1 irq", host_irq, 0);
    hwrite(A_IN, 32'hA5123456);
    hread(12'h100, v); check("R2 unmapped", v, 0);
    hread(A_IN, v);    check("R2 in readback", v, 32'hA5123456);
    hwrite(A_CMD, 32'h50000000);
    hread(A_CMD, v);   check("R2 cmd bits 30,28", v, 32'h50000000);
    hwrite(A_CMD, 32'h0);
  endtask

  task automatic t_host_claim;
    logic [31:0] v;
    hwrite(A_OWN, 2); hread(A_OWN, v); check("R3 host claim", v, 2);
    hwrite(A_OWN, 0); hread(A_OWN, v); check("R3 release", v, 0);
    hwrite(A_OWN, 1); hread(A_OWN, v); check("R4 host write 1", v, 0);
    hwrite(A_OWN, 3); hread(A_OWN, v); check("R4 host write 3", v, 0);
  endtask

  task automatic fw_pulse_claim;
    fw_claim = 1; @(posedge clk); @(negedge clk); fw_claim = 0;
  endtask

  task automatic t_fw_claim;
    logic [31:0] v;
    fw_pulse_claim(); hread(A_OWN, v); check("R3 fw claim", v, 1);
    hwrite(A_OWN, 2); hread(A_OWN, v); check("R4 host vs fw", v, 1);
    hwrite(A_OWN, 0); hread(A_OWN, v); check("R3 release fw", v, 0);
    hwrite(A_OWN, 2);
    fw_pulse_claim(); hread(A_OWN, v); check("R4 fw vs host", v, 2);
    hwrite(A_OWN, 0);
  endtask

  task automatic t_claim_race;
    logic [31:0] v;
    fw_claim = 1;
    hwrite(A_OWN, 2);
    fw_claim = 0;
    hread(A_OWN, v); check("R5 same-cycle claim", v, 1);
    hwrite(A_OWN, 0);
  endtask

  task automatic t_send;
    logic [31:0] v;
    hwrite(A_OWN, 2);
    hwrite(A_IN, 32'h12ABCDEF);
    hwrite(A_CMD, 32'h88000000);
    check("R6 doorbell high", fw_doorbell, 1);
    check("R6 inbox", fw_inbox, 32'h12ABCDEF);
    @(negedge clk);
    check("R6 doorbell one cycle", fw_doorbell, 0);
    hread(A_CMD, v); check("R6 bit27 consumed", v, 32'h80000000);
    hwrite(A_CMD, 32'h08000000);
    check("R6 no doorbell without bit31", fw_doorbell, 0);
    hwrite(A_OWN, 0);
  endtask

  task automatic t_ack;
    logic [31:0] v;
    fw_pulse_claim();
    hwrite(A_IN, 32'h02000000);
    hwrite(A_CMD, 32'h88000000);
    check("R7 doorbell while fw owns", fw_doorbell, 1);
    check("R7 inbox", fw_inbox, 32'h02000000);
    hread(A_OWN, v); check("R7 owner kept", v, 1);
    hwrite(A_OWN, 0);
  endtask

  task automatic fw_pulse_post(input logic [31:0] m);
    fw_msg = m; fw_post = 1; @(posedge clk); @(negedge clk); fw_post = 0;
  endtask

  task automatic t_post;
    logic [31:0] v;
    hwrite(A_CMD, 32'h80000000);
    fw_pulse_post(32'h0A123456);
    hread(A_OUT, v); check("R8 outbound", v, 32'h0A123456);
    hread(A_CMD, v); check("R8 bit29 set", v, 32'hA0000000);
    check("R8 irq", host_irq, 1);
    hwrite(A_CMD, v & ~32'h20000000);
    check("R8 irq cleared", host_irq, 0);
    hwrite(A_CMD, 32'h0);
    fw_pulse_post(32'h0B000001);
    check("R8 no irq without enable", host_irq, 0);
    hread(A_CMD, v); check("R8 bit29 without enable", v, 32'h20000000);
  endtask

  task automatic t_post_race;
    logic [31:0] v;
    hwrite(A_CMD, 32'hA0000000);
    fw_msg = 32'hC0FFEE01; fw_post = 1;
    hwrite(A_CMD, 32'h80000000);
    fw_post = 0;
    hread(A_CMD, v); check("R9 bit29 survives", v, 32'hA0000000);
    check("R9 irq", host_irq, 1);
    hread(A_OUT, v); check("R9 new message", v, 32'hC0FFEE01);
    hwrite(A_CMD, 32'h0);
  endtask

  task automatic t_hang;
    logic [31:0] v;
    hwrite(A_ST, 32'h8);
    check("R10 no irq before hang", host_irq, 0);
    fw_hang = 1; @(posedge clk); @(negedge clk); fw_hang = 0;
    hread(A_ST, v); check("R10 hang flag", v, 32'hA);
    check("R10 irq", host_irq, 1);
    hwrite(A_ST, v);
    hread(A_ST, v); check("R10 write-back clears", v, 32'h8);
    check("R10 irq dropped", host_irq, 0);
    fw_hang = 1;
    hwrite(A_ST, 32'hA);
    fw_hang = 0;
    hread(A_ST, v); check("R10 set wins", v, 32'hA);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_host_claim();
    t_fw_claim();
    t_claim_race();
    t_send();
    t_ack();
    t_post();
    t_post_race();
    t_hang();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule